// File: doc/BRIEF.md
# Mailbox Command Issue Engine

This block lets on-chip logic hand a single command to a power-management coprocessor that listens on three mailbox registers: a message register, an argument register and a response register. A client presents a 16-bit message index, a 32-bit parameter and a flag saying whether the coprocessor's reply word should be fetched. The engine then acts as a master on a simple register bus and carries out the whole exchange without further help from the client.

The exchange has three phases. First the engine polls the response register until it holds a nonzero value, and goes on only if that value reports that the previous command succeeded. Next it clears the response register and writes the parameter and the message index, in that order. Finally it polls the response register again until the coprocessor answers, and on success it optionally reads the reply back from the argument register. Each poll loop has a bounded number of reads, spaced by a microsecond delay taken from a clock divider. A timeout is reported apart from a failure answer.

Only one command may be in flight. The engine raises `busy` while it works and pulses `done` for one cycle along with a two-bit status and the reply word.

Top module: `mbox_cmd_engine`

## Requirements
- R1: A request whose message index is not below MSG_COUNT ends with status 3 (bad message) and makes no bus read or write.
- R2: Before any write, the engine reads the response register (address RSP_ADDR) until it returns nonzero. If that value is not 1, the command ends with status 1 (error) and no bus write is made.
- R3: After a pre-check value of 1, the engine makes exactly three writes on consecutive cycles: 0 to RSP_ADDR, then the parameter to ARG_ADDR, then the message index zero-extended to 32 bits to MSG_ADDR.
- R4: After the message write, the engine polls RSP_ADDR until it is nonzero. A value of 1 gives status 0 (ok) and any other nonzero value gives status 1 (error).
- R5: Each poll phase makes at most POLL_LIMIT reads of the response register. When all of them return zero, the command ends with status 2 (timeout) and, in the pre-check phase, no write is made.
- R6: After a response read returns zero and the budget is not used up, the next response read strobe is issued exactly CLKS_PER_US + 1 cycles after the cycle in which the zero was returned.
- R7: When the command succeeds and a reply was requested, the engine makes one read of ARG_ADDR and returns that value on `reply`. In every other case `reply` is 0 when `done` pulses.
- R8: `done` is high for exactly one cycle, with `status` and `reply` valid in that cycle. `busy` is high from the cycle after a request is accepted through the `done` cycle, and requests presented while `busy` is high are ignored.
- R9: During and right after reset, `busy`, `done`, `bus_we` and `bus_re` are low. While `busy` is low, no bus strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Command request, taken when the engine is idle |
| req_msg | input | MSG_W (16) | Message index |
| req_param | input | DATA_W (32) | Parameter written to the argument register |
| req_want_reply | input | 1 | Fetch the reply word after success |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 error, 2 timeout, 3 bad message; valid with done |
| reply | output | DATA_W (32) | Reply word; valid with done |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_we | output | 1 | Write strobe, one cycle per write |
| bus_re | output | 1 | Read strobe, one cycle per read |
| bus_rdata | input | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | input | 1 | Read data valid, any cycle after bus_re |

## Verification
The hardest situation to reach from the ports is a poll phase that runs its budget to the last read, or stops exactly one read short, while the other phase behaves differently. The bench reaches it with a scripted bus responder that returns a chosen number of zero reads before a chosen final value, set apart for the pre-check and the answer phase. It sweeps that count across and past the poll limit with two read latencies, and it times the spacing between successive response reads.

// File: rtl/mbox_pkg.sv
// Shared types for the mailbox command issue engine.
// Assumes: nothing beyond the standard language.
package mbox_pkg;

    // Completion codes reported with done.
    typedef enum logic [1:0] {
        MB_OK      = 2'd0,
        MB_ERR     = 2'd1,
        MB_TIMEOUT = 2'd2,
        MB_BADMSG  = 2'd3
    } mbox_status_e;

    // Sequencer states.
    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_RSP,
        S_WAIT_RSP,
        S_DELAY,
        S_CLR,
        S_WR_ARG,
        S_WR_MSG,
        S_RD_ARG,
        S_WAIT_ARG,
        S_DONE
    } mbox_state_e;

endpackage

// File: rtl/mbox_usec_tick.sv
// Microsecond delay timer.
// Counts clock cycles while run is high and pulses tick on the
// CLKS_PER_US-th cycle of a run; the count restarts whenever run is low.
// Assumes: CLKS_PER_US >= 1.
module mbox_usec_tick #(
    parameter int CLKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(CLKS_PER_US) + 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(CLKS_PER_US - 1));

    // Advance the divider while running, restart otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/mbox_poll_budget.sv
// Poll budget counter.
// Counts zero-valued response reads in one poll phase; last is high when
// the read now being counted is the final one allowed.
// Assumes: POLL_LIMIT >= 1; clr and inc are never high together.
module mbox_poll_budget #(
    parameter int POLL_LIMIT = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(POLL_LIMIT) + 1;

    logic [CW-1:0] used_q;

    assign last = (used_q == CW'(POLL_LIMIT - 1));

    // Track how many zero reads this phase has seen.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            used_q <= '0;
        end else if (inc && !last) begin
            used_q <= used_q + CW'(1);
        end
    end
endmodule

// File: rtl/mbox_cmd_engine.sv
// Mailbox command issue engine (top).
// Takes one command at a time, checks that the mailbox reports the last
// command as successful, clears the response register, writes argument
// then message, polls for the answer and optionally reads the reply.
// Assumes: a register bus where a write completes in its strobe cycle and
// a read returns data with bus_rvalid in some later cycle.
module mbox_cmd_engine
    import mbox_pkg::*;
#(
    parameter int          MSG_W       = 16,
    parameter int          DATA_W      = 32,
    parameter int          ADDR_W      = 8,
    parameter int          MSG_COUNT   = 64,
    parameter int          POLL_LIMIT  = 2000,
    parameter int          CLKS_PER_US = 100,
    parameter [ADDR_W-1:0] MSG_ADDR    = 8'h42,
    parameter [ADDR_W-1:0] ARG_ADDR    = 8'h52,
    parameter [ADDR_W-1:0] RSP_ADDR    = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [MSG_W-1:0]  req_msg,
    input  logic [DATA_W-1:0] req_param,
    input  logic              req_want_reply,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [DATA_W-1:0] reply,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_rvalid
);
    localparam logic [DATA_W-1:0] RSP_PASS = DATA_W'(1);

    mbox_state_e       state_q;
    mbox_status_e      status_q;
    logic [MSG_W-1:0]  msg_q;
    logic [DATA_W-1:0] param_q;
    logic [DATA_W-1:0] reply_q;
    logic              want_q;
    logic              post_q;
    logic              tick;
    logic              poll_last;
    logic              poll_clr;
    logic              poll_inc;
    logic              rsp_zero;

    assign rsp_zero = (bus_rdata == '0);
    assign poll_clr = (state_q == S_IDLE) || (state_q == S_WR_MSG);
    assign poll_inc = (state_q == S_WAIT_RSP) && bus_rvalid && rsp_zero;

    mbox_usec_tick #(.CLKS_PER_US(CLKS_PER_US)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == S_DELAY),
        .tick  (tick)
    );

    mbox_poll_budget #(.POLL_LIMIT(POLL_LIMIT)) budget_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (poll_clr),
        .inc   (poll_inc),
        .last  (poll_last)
    );

    // Sequence one command from acceptance to completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            status_q <= MB_OK;
            msg_q    <= '0;
            param_q  <= '0;
            reply_q  <= '0;
            want_q   <= 1'b0;
            post_q   <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        msg_q   <= req_msg;
                        param_q <= req_param;
                        want_q  <= req_want_reply;
                        reply_q <= '0;
                        post_q  <= 1'b0;
                        if (32'(req_msg) >= 32'(MSG_COUNT)) begin
                            status_q <= MB_BADMSG;
                            state_q  <= S_DONE;
                        end else begin
                            state_q  <= S_RD_RSP;
                        end
                    end
                end
                S_RD_RSP: state_q <= S_WAIT_RSP;
                S_WAIT_RSP: begin
                    if (bus_rvalid) begin
                        if (!rsp_zero) begin
                            if (bus_rdata != RSP_PASS) begin
                                status_q <= MB_ERR;
                                state_q  <= S_DONE;
                            end else if (!post_q) begin
                                state_q  <= S_CLR;
                            end else if (want_q) begin
                                state_q  <= S_RD_ARG;
                            end else begin
                                status_q <= MB_OK;
                                state_q  <= S_DONE;
                            end
                        end else if (poll_last) begin
                            status_q <= MB_TIMEOUT;
                            state_q  <= S_DONE;
                        end else begin
                            state_q  <= S_DELAY;
                        end
                    end
                end
                S_DELAY:  if (tick) state_q <= S_RD_RSP;
                S_CLR:    state_q <= S_WR_ARG;
                S_WR_ARG: state_q <= S_WR_MSG;
                S_WR_MSG: begin
                    post_q  <= 1'b1;
                    state_q <= S_RD_RSP;
                end
                S_RD_ARG: state_q <= S_WAIT_ARG;
                S_WAIT_ARG: begin
                    if (bus_rvalid) begin
                        reply_q  <= bus_rdata;
                        status_q <= MB_OK;
                        state_q  <= S_DONE;
                    end
                end
                S_DONE:   state_q <= S_IDLE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    // Drive bus strobes, address and data from the current state.
    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_addr  = RSP_ADDR;
        bus_wdata = '0;
        case (state_q)
            S_RD_RSP: bus_re = 1'b1;
            S_CLR:    bus_we = 1'b1;
            S_WR_ARG: begin
                bus_we    = 1'b1;
                bus_addr  = ARG_ADDR;
                bus_wdata = param_q;
            end
            S_WR_MSG: begin
                bus_we    = 1'b1;
                bus_addr  = MSG_ADDR;
                bus_wdata = DATA_W'(msg_q);
            end
            S_RD_ARG: begin
                bus_re    = 1'b1;
                bus_addr  = ARG_ADDR;
            end
            default: ;
        endcase
    end

    assign busy   = (state_q != S_IDLE);
    assign done   = (state_q == S_DONE);
    assign status = status_q;
    assign reply  = reply_q;
endmodule

// File: rtl/mbox_cmd_engine_chk.sv
// Protocol checker for the mailbox command issue engine.
// Watches the client handshake and bus strobes; attached by bind below.
// Assumes: synchronous active-low reset shared with the engine.
module mbox_cmd_engine_chk #(
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 8,
    parameter [ADDR_W-1:0] MSG_ADDR = 8'h42,
    parameter [ADDR_W-1:0] ARG_ADDR = 8'h52,
    parameter [ADDR_W-1:0] RSP_ADDR = 8'h5A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              bus_re
);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bus_we || bus_re));

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    assert_arg_after_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ARG_ADDR) |->
            ($past(bus_we) && $past(bus_addr) == RSP_ADDR && $past(bus_wdata) == '0));

    assert_msg_after_arg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == MSG_ADDR) |->
            ($past(bus_we) && $past(bus_addr) == ARG_ADDR));
endmodule

bind mbox_cmd_engine mbox_cmd_engine_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .MSG_ADDR (MSG_ADDR),
    .ARG_ADDR (ARG_ADDR),
    .RSP_ADDR (RSP_ADDR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re)
);

// File: tb/mbox_cmd_engine_tb_top.sv
// Bench for the mailbox command issue engine: sweeps scripted mailbox
// behaviour over a small configuration and checks every completion.
module mbox_cmd_engine_tb_top;
    localparam int          NUS  = 3;
    localparam int          PL   = 4;
    localparam int          MC   = 8;
    localparam [7:0]        A_MSG = 8'h42;
    localparam [7:0]        A_ARG = 8'h52;
    localparam [7:0]        A_RSP = 8'h5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_msg = '0;
    logic [31:0] req_param = '0;
    logic        req_want_reply = 1'b0;
    logic        busy, done;
    logic [1:0]  status;
    logic [31:0] reply;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we, bus_re;
    logic [31:0] bus_rdata = '0;
    logic        bus_rvalid = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;   // 250 MHz

    mbox_cmd_engine #(
        .MSG_COUNT(MC), .POLL_LIMIT(PL), .CLKS_PER_US(NUS),
        .MSG_ADDR(A_MSG), .ARG_ADDR(A_ARG), .RSP_ADDR(A_RSP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_msg(req_msg),
        .req_param(req_param), .req_want_reply(req_want_reply), .busy(busy),
        .done(done), .status(status), .reply(reply), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    // Scripted mailbox responder configuration, set by the stimulus.
    int          cfg_pz = 0, cfg_qz = 0, cfg_lat = 1;
    logic [31:0] cfg_pv = 1, cfg_qv = 1, cfg_rv = 0;
    logic        sl_clear = 1'b0;

    // Responder state and observations.
    int          pre_rd, post_rd, arg_rd, wcnt, pend, gap_cnt, prev_cyc;
    logic        post_ph, have_prev, gap_bad;
    logic [31:0] pdata;
    logic [7:0]  wa [0:7];
    logic [31:0] wd [0:7];

    always @(posedge clk) cyc <= cyc + 1;

    // Responder: logs writes, answers reads after cfg_lat cycles.
    always @(posedge clk) begin
        bus_rvalid <= 1'b0;
        if (sl_clear) begin
            pre_rd <= 0; post_rd <= 0; arg_rd <= 0; wcnt <= 0; pend <= 0;
            post_ph <= 1'b0; have_prev <= 1'b0; gap_bad <= 1'b0; gap_cnt <= 0;
        end else begin
            if (pend != 0) begin
                pend <= pend - 1;
                if (pend == 1) begin
                    bus_rvalid <= 1'b1;
                    bus_rdata  <= pdata;
                end
            end
            if (bus_we) begin
                if (wcnt < 8) begin
                    wa[wcnt] <= bus_addr;
                    wd[wcnt] <= bus_wdata;
                end
                wcnt <= wcnt + 1;
                if (bus_addr == A_MSG) begin
                    post_ph   <= 1'b1;
                    have_prev <= 1'b0;
                end
            end
            if (bus_re) begin
                pend <= cfg_lat;
                if (bus_addr == A_RSP) begin
                    if (have_prev) begin
                        gap_cnt <= gap_cnt + 1;
                        if (cyc - prev_cyc != NUS + cfg_lat + 2) gap_bad <= 1'b1;
                    end
                    have_prev <= 1'b1;
                    prev_cyc  <= cyc;
                    if (post_ph) begin
                        pdata   <= (post_rd < cfg_qz) ? 32'd0 : cfg_qv;
                        post_rd <= post_rd + 1;
                    end else begin
                        pdata  <= (pre_rd < cfg_pz) ? 32'd0 : cfg_pv;
                        pre_rd <= pre_rd + 1;
                    end
                end else begin
                    pdata  <= cfg_rv;
                    arg_rd <= arg_rd + 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // One command: configure responder, issue, wait, compare.
    task automatic run_cmd(input logic [15:0] msg, input logic [31:0] prm,
                           input bit want, input int pz, input logic [31:0] pv,
                           input int qz, input logic [31:0] qv,
                           input logic [31:0] rv, input int lat, input bit inject);
        int   est, exp_w, exp_pre, exp_post, exp_arg;
        logic [31:0] exp_reply;
        bit   badmsg, pre_ok;
        cfg_pz = pz; cfg_pv = pv; cfg_qz = qz; cfg_qv = qv; cfg_rv = rv; cfg_lat = lat;
        @(negedge clk); sl_clear = 1'b1;
        @(negedge clk); sl_clear = 1'b0;
        req_valid = 1'b1; req_msg = msg; req_param = prm; req_want_reply = want;
        @(negedge clk);
        chk(busy == 1'b1, "R8", "busy after accept", 32'(busy), 1);
        if (inject) begin
            req_msg = msg ^ 16'h0001; req_param = ~prm; req_want_reply = ~want;
        end else begin
            req_valid = 1'b0;
        end
        while (!done) begin
            @(negedge clk);
            if (!done && !busy) chk(1'b0, "R8", "busy dropped early", 0, 1);
        end
        req_valid = 1'b0;
        // expected outcome from the requirements
        badmsg   = (32'(msg) >= MC);
        pre_ok   = !badmsg && (pz < PL) && (pv == 1);
        exp_pre  = badmsg ? 0 : ((pz >= PL) ? PL : pz + 1);
        exp_post = !pre_ok ? 0 : ((qz >= PL) ? PL : qz + 1);
        exp_w    = pre_ok ? 3 : 0;
        if (badmsg)            est = 3;
        else if (pz >= PL)     est = 2;
        else if (pv != 1)      est = 1;
        else if (qz >= PL)     est = 2;
        else if (qv != 1)      est = 1;
        else                   est = 0;
        exp_arg   = (est == 0 && want) ? 1 : 0;
        exp_reply = (est == 0 && want) ? rv : 32'd0;
        if (badmsg)
            chk(status == 2'd3 && pre_rd == 0 && wcnt == 0, "R1", "bad message",
                {status, 8'(pre_rd), 8'(wcnt)}, 32'h300);
        else if (pz >= PL || (qz >= PL && pre_ok))
            chk(status == 2'd2, "R5", "timeout status", 32'(status), 2);
        else if (pv != 1 || (qv != 1 && pre_ok))
            chk(status == 2'(est), est == 1 && pv != 1 ? "R2" : "R4", "error status",
                32'(status), 32'(est));
        else
            chk(status == 2'd0, "R4", "ok status", 32'(status), 0);
        chk(pre_rd == exp_pre, "R5", "pre-check reads", 32'(pre_rd), 32'(exp_pre));
        chk(post_rd == exp_post, "R5", "answer reads", 32'(post_rd), 32'(exp_post));
        chk(wcnt == exp_w, "R2", "write count", 32'(wcnt), 32'(exp_w));
        if (exp_w == 3) begin
            chk(wa[0] == A_RSP && wd[0] == 0, "R3", "first write", {wa[0], wd[0][23:0]}, {A_RSP, 24'd0});
            chk(wa[1] == A_ARG && wd[1] == prm, "R3", "second write data", wd[1], prm);
            chk(wa[2] == A_MSG && wd[2] == {16'd0, msg}, "R3", "third write data", wd[2], {16'd0, msg});
        end
        chk(arg_rd == exp_arg, "R7", "reply reads", 32'(arg_rd), 32'(exp_arg));
        chk(reply == exp_reply, "R7", "reply value", reply, exp_reply);
        if (gap_cnt > 0) chk(!gap_bad, "R6", "poll spacing", 32'(gap_bad), 0);
        @(negedge clk);
        chk(!done && !busy, "R8", "done single cycle", {30'd0, done, busy}, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        sl_clear = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_we && !bus_re, "R9", "in reset",
            {28'd0, busy, done, bus_we, bus_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !bus_we && !bus_re, "R9", "after reset",
            {28'd0, busy, done, bus_we, bus_re}, 0);
        sl_clear = 1'b0;
        // R1 boundary: first invalid index, a larger one, the maximum, last valid
        run_cmd(16'd8, 32'h11, 1'b1, 0, 1, 0, 1, 32'h77, 1, 1'b0);
        run_cmd(16'd9, 32'h12, 1'b0, 0, 1, 0, 1, 32'h77, 1, 1'b0);
        run_cmd(16'hFFFF, 32'h13, 1'b1, 0, 1, 0, 1, 32'h77, 2, 1'b0);
        run_cmd(16'd7, 32'h14, 1'b1, 0, 1, 0, 1, 32'h77, 1, 1'b0);
        // sweep both poll phases across and past the limit
        for (int pz = 0; pz <= PL; pz++)
            for (int pvi = 0; pvi < 2; pvi++)
                for (int qz = 0; qz <= PL; qz++)
                    for (int qvi = 0; qvi < 2; qvi++)
                        for (int w = 0; w < 2; w++)
                            for (int lat = 1; lat <= 2; lat++)
                                run_cmd(16'((pz * 3 + qz) % MC),
                                        32'hA500_0000 + 32'(pz * 100 + qz * 10 + w),
                                        w[0], pz, pvi ? 32'd6 : 32'd1,
                                        qz, qvi ? 32'd3 : 32'd1,
                                        32'hC0DE_0000 + 32'(qz), lat, 1'b0);
        // requests held during a command are ignored (R8)
        run_cmd(16'd2, 32'h5555_AAAA, 1'b1, 2, 1, 1, 1, 32'h1234, 1, 1'b1);
        run_cmd(16'd4, 32'h0F0F_F0F0, 1'b0, 0, 1, 3, 1, 32'h9999, 2, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule